// File: doc/BRIEF.md
# Supervisor Control and Status Registers

This block holds the two byte-wide registers of a supervisory controller and the event logic behind them. A control byte sets the clock-alarm enable, the oscillator enable, the watchdog enable, the pin that carries the watchdog alarm, a two-bit battery threshold code and the battery-monitor enable. A status byte gathers sticky event flags. Software can read it, and any write to it wipes it.

Two small state machines sit behind the registers. The watchdog machine has the states WD_OFF, WD_RUN and WD_FIRED. It counts one-second ticks. It goes back to zero on a watchdog enable edge, on a main-supply power-up pulse or on a rising edge of the kick input. On timeout it raises the watchdog alarm flag. The battery scheduler has the states BT_IDLE, BT_PEND and BT_TEST. It asks an external comparator for a test when the monitor enable goes high, on main-supply power-up and on each hour tick. A test that fails sets the battery alarm flag. Two active-low pins report the alarms: a dedicated watchdog pin and a shared alarm pin.

Watchdog transitions: WD_OFF→WD_RUN when the enable is 1 (count cleared). WD_RUN→WD_RUN with the count cleared on a restart, or the count stepped on a tick. WD_RUN→WD_FIRED on the final tick. WD_FIRED→WD_RUN on a restart. Any state→WD_OFF when the enable is 0. Scheduler transitions: BT_IDLE→BT_TEST on a trigger while the oscillator runs, and BT_IDLE→BT_PEND on a trigger while it is halted. BT_PEND→BT_TEST once the oscillator runs. BT_TEST→BT_IDLE on a result. BT_PEND or BT_TEST→BT_IDLE when the monitor is disabled.

Top module: `supv_csr`

## Requirements
- R1: After the battery power-up reset (rst_n low), both registers read 00h, batt_req is 0 and both alarm pins are high.
- R2: A control write (wr_en=1, wr_sel=0) stores wr_data[6:0] in the next cycle. Bit 7 always reads 0. The fields are: bit 0 clock-alarm enable, bit 1 oscillator enable, bit 2 watchdog enable, bit 3 watchdog pin select, bits 5:4 trip code, bit 6 battery-monitor enable.
- R3: batt_trip always equals control bits 5:4 without change. The codes 00/01/10/11 stand for nominal 1.75/2.00/2.25/2.50 V thresholds.
- R4: A status write (wr_en=1, wr_sel=1) clears every status bit, whatever the data. An event input that is active in the same cycle still sets its bit. Bit 7 reads 0.
- R5: Status fields: bit 6 battery alarm, bit 5 write-protect, bit 4 power-on (vcc_por), bit 3 brown-out, bit 2 clock alarm, bit 1 watchdog alarm, bit 0 reset. A one-cycle high on an event input sets its bit, and the bit stays set until a status write.
- R6: With the watchdog enabled, the watchdog alarm bit is set one cycle after the WD_SECS-th sec_tick that follows the last restart, and not earlier.
- R7: The watchdog count restarts at zero on a 0→1 change of the enable, on vcc_por, or on a rising edge of wd_kick. When a restart and a tick fall in the same cycle, the restart wins.
- R8: While the watchdog enable is 0, ticks never raise the watchdog alarm.
- R9: wdo_n is low exactly when the watchdog alarm bit, the watchdog enable and not-select are all 1. alm_n is low when (watchdog alarm bit, enable and select are all 1) or (clock alarm bit and clock-alarm enable are both 1).
- R10: While the monitor enable is 1, its rising edge, vcc_por or hour_tick raises batt_req in the next cycle (oscillator running). batt_req stays high until batt_done. A trigger while the monitor enable is 0 has no effect.
- R11: No test is requested while the oscillator enable is 0. The request is held pending, and batt_req rises one cycle after the oscillator enable reads 1.
- R12: batt_done together with batt_fail sets the battery alarm bit only while the monitor enable is 1. A passing result sets nothing. Clearing the monitor enable during a test abandons the test.
- R13: Once the watchdog has fired, further ticks have no effect until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Battery power-up reset, active low |
| vcc_por | input | 1 | Main-supply power-up pulse |
| sec_tick | input | 1 | One-second tick pulse |
| hour_tick | input | 1 | On-the-hour pulse |
| wd_kick | input | 1 | Watchdog kick input (rising edge restarts) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 8 | Write data |
| evt_clk | input | 1 | Clock alarm match event |
| evt_bor | input | 1 | Brown-out event |
| evt_wp | input | 1 | Write-protect event |
| evt_rst | input | 1 | Reset event |
| batt_done | input | 1 | Comparator result valid |
| batt_fail | input | 1 | Comparator result: battery below threshold |
| ctrl_q | output | 8 | Control register contents |
| stat_q | output | 8 | Status register contents |
| batt_req | output | 1 | Battery test request |
| batt_trip | output | 2 | Trip code to the comparator |
| alm_n | output | 1 | Shared alarm pin, active low |
| wdo_n | output | 1 | Watchdog alarm pin, active low |

## Verification
The watchdog is driven with plain tick runs, with runs broken by a kick, with a kick or a power-up pulse in the same cycle as a tick, and with ticks after it has fired. This separates an off-by-one in the timeout, a restart that loses to a tick, and a fired state that keeps counting. The scheduler is started by each of its three triggers, with the oscillator halted and then started, with pass and fail results, and with the monitor disabled in the middle of a test. Each run shows whether a trigger is gated, held or dropped. Status writes with zero data, all-ones data and a same-cycle event show that the clear ignores the data and that a same-cycle event takes precedence over it.

// File: rtl/supv_pkg.sv
package supv_pkg;
    localparam int REG_W = 8;

    // control field positions
    localparam int C_CAE  = 0;
    localparam int C_OSCE = 1;
    localparam int C_WDE  = 2;
    localparam int C_WSEL = 3;
    localparam int C_TRLO = 4;
    localparam int C_TRHI = 5;
    localparam int C_BME  = 6;

    // status field positions
    localparam int S_RST  = 0;
    localparam int S_WDA  = 1;
    localparam int S_CLKA = 2;
    localparam int S_BOR  = 3;
    localparam int S_POR  = 4;
    localparam int S_WP   = 5;
    localparam int S_BATA = 6;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_t;

    typedef enum logic [1:0] {
        BT_IDLE = 2'd0,
        BT_PEND = 2'd1,
        BT_TEST = 2'd2
    } bt_state_t;
endpackage

// File: rtl/supv_ctrl_reg.sv
module supv_ctrl_reg
    import supv_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q,
    output logic         bme_rise
);
    localparam logic [W-1:0] WMASK = {1'b0, {(W-1){1'b1}}};

    logic bme_prev;
    logic ctrl_wr;

    assign ctrl_wr = wr_en & ~wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            bme_prev <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= wr_data & WMASK;
            end
            bme_prev <= ctrl_q[C_BME];
        end
    end

    assign bme_rise = ctrl_q[C_BME] & ~bme_prev;

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q[W-2:0] == $past(wr_data[W-2:0]));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));
endmodule

// File: rtl/supv_stat_reg.sv
module supv_stat_reg
    import supv_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] stat_d;

    always_comb begin
        stat_d = clr ? '0 : stat_q;
        stat_d = stat_d | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    // R4
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> stat_q == '0);

    // R5
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (stat_q & $past(stat_q)) == $past(stat_q));
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int WD_SECS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wde,
    input  logic vcc_por,
    input  logic kick,
    input  logic sec_tick,
    output logic expire
);
    localparam int CNT_W = $clog2(WD_SECS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_SECS - 1);

    wd_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            kick_q;
    logic            restart;

    assign restart = vcc_por | (kick & ~kick_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
            kick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            kick_q  <= kick;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_OFF: begin
                cnt_d = '0;
                if (wde) begin
                    state_d = WD_RUN;
                end
            end
            WD_RUN: begin
                if (!wde) begin
                    state_d = WD_OFF;
                    cnt_d   = '0;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (sec_tick) begin
                    if (cnt_q == LAST) begin
                        state_d = WD_FIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WD_FIRED: begin
                cnt_d = '0;
                if (!wde) begin
                    state_d = WD_OFF;
                end else if (restart) begin
                    state_d = WD_RUN;
                end
            end
            default: begin
                state_d = WD_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        expire = (state_q == WD_RUN) && wde && !restart && sec_tick && (cnt_q == LAST);
    end

    // R7
    wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wde && restart) |=> (state_q == WD_RUN && cnt_q == '0));

    // R8
    wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wde |=> state_q == WD_OFF);

    // R13
    wd_fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRED && wde && !restart) |=> state_q == WD_FIRED);
endmodule

// File: rtl/supv_batt_sched.sv
module supv_batt_sched
    import supv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bme,
    input  logic bme_rise,
    input  logic osce,
    input  logic vcc_por,
    input  logic hour_tick,
    input  logic done,
    input  logic fail,
    output logic req,
    output logic set_bata
);
    bt_state_t state_q, state_d;
    logic      trig;

    assign trig = bme & (bme_rise | vcc_por | hour_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_IDLE: begin
                if (trig) begin
                    state_d = osce ? BT_TEST : BT_PEND;
                end
            end
            BT_PEND: begin
                if (!bme) begin
                    state_d = BT_IDLE;
                end else if (osce) begin
                    state_d = BT_TEST;
                end
            end
            BT_TEST: begin
                if (!bme || done) begin
                    state_d = BT_IDLE;
                end
            end
            default: state_d = BT_IDLE;
        endcase
    end

    always_comb begin
        req      = (state_q == BT_TEST);
        set_bata = (state_q == BT_TEST) && bme && done && fail;
    end

    // R11
    bt_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(osce));

    // R12
    bt_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bme) |=> !req);
endmodule

// File: rtl/supv_csr.sv
module supv_csr
    import supv_pkg::*;
#(
    parameter int WD_SECS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_por,
    input  logic       sec_tick,
    input  logic       hour_tick,
    input  logic       wd_kick,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       evt_clk,
    input  logic       evt_bor,
    input  logic       evt_wp,
    input  logic       evt_rst,
    input  logic       batt_done,
    input  logic       batt_fail,
    output logic [7:0] ctrl_q,
    output logic [7:0] stat_q,
    output logic       batt_req,
    output logic [1:0] batt_trip,
    output logic       alm_n,
    output logic       wdo_n
);
    logic       bme_rise;
    logic       wd_expire;
    logic       bata_set;
    logic [7:0] set_vec;
    logic       wd_active;

    supv_ctrl_reg #(.W(REG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .bme_rise (bme_rise)
    );

    supv_wdog #(.WD_SECS(WD_SECS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wde      (ctrl_q[C_WDE]),
        .vcc_por  (vcc_por),
        .kick     (wd_kick),
        .sec_tick (sec_tick),
        .expire   (wd_expire)
    );

    supv_batt_sched u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bme       (ctrl_q[C_BME]),
        .bme_rise  (bme_rise),
        .osce      (ctrl_q[C_OSCE]),
        .vcc_por   (vcc_por),
        .hour_tick (hour_tick),
        .done      (batt_done),
        .fail      (batt_fail),
        .req       (batt_req),
        .set_bata  (bata_set)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[S_RST]  = evt_rst;
        set_vec[S_WDA]  = wd_expire;
        set_vec[S_CLKA] = evt_clk;
        set_vec[S_BOR]  = evt_bor;
        set_vec[S_POR]  = vcc_por;
        set_vec[S_WP]   = evt_wp;
        set_vec[S_BATA] = bata_set;
    end

    supv_stat_reg #(.W(REG_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_en & wr_sel),
        .set_vec (set_vec),
        .stat_q  (stat_q)
    );

    always_comb begin
        wd_active = stat_q[S_WDA] & ctrl_q[C_WDE];
        batt_trip = ctrl_q[C_TRHI:C_TRLO];
        wdo_n     = ~(wd_active & ~ctrl_q[C_WSEL]);
        alm_n     = ~((wd_active & ctrl_q[C_WSEL]) | (stat_q[S_CLKA] & ctrl_q[C_CAE]));
    end

    // R9
    pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wdo_n |-> (stat_q[S_WDA] && !ctrl_q[C_WSEL]));

    // R6
    wda_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[S_WDA]) |-> $past(ctrl_q[C_WDE]));
endmodule

// File: tb/tb_supv_csr.sv
module tb_supv_csr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_por = 1'b0, sec_tick = 1'b0, hour_tick = 1'b0, wd_kick = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       evt_clk = 1'b0, evt_bor = 1'b0, evt_wp = 1'b0, evt_rst = 1'b0;
    logic       batt_done = 1'b0, batt_fail = 1'b0;
    logic [7:0] ctrl_q, stat_q;
    logic       batt_req, alm_n, wdo_n;
    logic [1:0] batt_trip;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [20:0] exp;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_csr #(.WD_SECS(4)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_por(vcc_por), .sec_tick(sec_tick),
        .hour_tick(hour_tick), .wd_kick(wd_kick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .evt_clk(evt_clk), .evt_bor(evt_bor), .evt_wp(evt_wp),
        .evt_rst(evt_rst), .batt_done(batt_done), .batt_fail(batt_fail),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .batt_req(batt_req), .batt_trip(batt_trip),
        .alm_n(alm_n), .wdo_n(wdo_n)
    );

    // monitor: compare one queued item per falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [20:0] obs;
        if (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            obs = {ctrl_q, stat_q, alm_n, wdo_n, batt_req, batt_trip};
            vectors++;
            if (obs !== it.exp) begin
                miscompares++;
                $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // driver side of the scoreboard: expected item from requirement formulas
    task automatic expect_state(string tag, logic [7:0] c, logic [7:0] s, logic req);
        item_t it;
        logic  a_n, w_n;
        w_n = ~(s[1] & c[2] & ~c[3]);
        a_n = ~((s[1] & c[2] & c[3]) | (s[2] & c[0]));
        it.tag = tag;
        it.exp = {c, s, a_n, w_n, req, c[5:4]};
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; cyc(); sec_tick = 1'b0; cyc();
        end
    endtask

    task automatic kick();
        wd_kick = 1'b1; cyc(); wd_kick = 1'b0; cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        expect_state("R1 reset", 8'h00, 8'h00, 1'b0);

        // control layout and trip code
        wr(0, 8'h91);
        expect_state("R2 R3 write 91 trip 01", 8'h11, 8'h00, 1'b0);
        wr(0, 8'h3A);
        expect_state("R3 trip 11", 8'h3A, 8'h00, 1'b0);
        wr(0, 8'h80);
        expect_state("R2 bit7 ignored", 8'h00, 8'h00, 1'b0);

        // status flags
        evt_clk = 1'b1; evt_bor = 1'b1; cyc(); evt_clk = 1'b0; evt_bor = 1'b0;
        expect_state("R5 clk+bor flags, R9 alarm gated", 8'h00, 8'h0C, 1'b0);
        wr(0, 8'h01);
        expect_state("R9 clock alarm pin", 8'h01, 8'h0C, 1'b0);
        wr(1, 8'h00);
        expect_state("R4 clear with zero data", 8'h01, 8'h00, 1'b0);
        evt_wp = 1'b1; wr(1, 8'hFF); evt_wp = 1'b0;
        expect_state("R4 same-cycle event survives", 8'h01, 8'h20, 1'b0);
        evt_rst = 1'b1; vcc_por = 1'b1; cyc(); evt_rst = 1'b0; vcc_por = 1'b0;
        expect_state("R5 rst+por sticky", 8'h01, 8'h31, 1'b0);
        wr(1, 8'h5A);
        expect_state("R4 clear with pattern data", 8'h01, 8'h00, 1'b0);

        // watchdog timeout
        wr(0, 8'h04); cyc();
        tick(3);
        expect_state("R6 no alarm before timeout", 8'h04, 8'h00, 1'b0);
        tick(1);
        expect_state("R6 alarm at timeout, R9 wdo pin", 8'h04, 8'h02, 1'b0);
        wr(0, 8'h0C);
        expect_state("R9 routed to shared pin", 8'h0C, 8'h02, 1'b0);
        wr(1, 8'h00);
        tick(5);
        expect_state("R13 fired ignores ticks", 8'h0C, 8'h00, 1'b0);
        kick();
        tick(3);
        expect_state("R7 kick restarts from fired", 8'h0C, 8'h00, 1'b0);
        tick(1);
        expect_state("R7 timeout after kick", 8'h0C, 8'h02, 1'b0);

        // kick coincident with tick
        wr(1, 8'h00);
        kick();
        tick(3);
        sec_tick = 1'b1; wd_kick = 1'b1; cyc(); sec_tick = 1'b0; wd_kick = 1'b0; cyc();
        expect_state("R7 kick beats tick", 8'h0C, 8'h00, 1'b0);
        tick(3);
        expect_state("R7 count from kick", 8'h0C, 8'h00, 1'b0);
        tick(1);
        expect_state("R7 timeout after tie", 8'h0C, 8'h02, 1'b0);

        // power-up pulse coincident with tick
        wr(1, 8'h00);
        kick();
        tick(3);
        sec_tick = 1'b1; vcc_por = 1'b1; cyc(); sec_tick = 1'b0; vcc_por = 1'b0; cyc();
        expect_state("R7 por beats tick", 8'h0C, 8'h10, 1'b0);
        tick(3);
        expect_state("R7 count from por", 8'h0C, 8'h10, 1'b0);
        tick(1);
        expect_state("R7 timeout after por", 8'h0C, 8'h12, 1'b0);

        // disabled watchdog
        wr(0, 8'h08);
        expect_state("R9 pins masked when disabled", 8'h08, 8'h12, 1'b0);
        wr(1, 8'h00);
        tick(8);
        expect_state("R8 no alarm while disabled", 8'h08, 8'h00, 1'b0);
        wr(0, 8'h0C); cyc();
        tick(3);
        expect_state("R7 enable edge restarts", 8'h0C, 8'h00, 1'b0);
        tick(1);
        expect_state("R7 timeout after enable", 8'h0C, 8'h02, 1'b0);
        wr(0, 8'h00);
        wr(1, 8'h00);
        expect_state("R1 cleanup", 8'h00, 8'h00, 1'b0);

        // battery scheduling
        wr(0, 8'h40);
        cyc(); cyc();
        expect_state("R11 held while oscillator off", 8'h40, 8'h00, 1'b0);
        wr(0, 8'h42);
        expect_state("R11 not yet requested", 8'h42, 8'h00, 1'b0);
        cyc();
        expect_state("R11 request after osc on", 8'h42, 8'h00, 1'b1);
        batt_done = 1'b1; batt_fail = 1'b1; cyc(); batt_done = 1'b0; batt_fail = 1'b0;
        expect_state("R12 fail sets battery alarm", 8'h42, 8'h40, 1'b0);
        wr(1, 8'h00);
        hour_tick = 1'b1; cyc(); hour_tick = 1'b0;
        expect_state("R10 hour trigger", 8'h42, 8'h00, 1'b1);
        batt_done = 1'b1; cyc(); batt_done = 1'b0;
        expect_state("R12 pass sets nothing", 8'h42, 8'h00, 1'b0);
        vcc_por = 1'b1; cyc(); vcc_por = 1'b0;
        expect_state("R10 power-up trigger", 8'h42, 8'h10, 1'b1);
        batt_done = 1'b1; cyc(); batt_done = 1'b0;
        expect_state("R10 request ends on done", 8'h42, 8'h10, 1'b0);
        wr(1, 8'h00);
        wr(0, 8'h02);
        hour_tick = 1'b1; cyc(); hour_tick = 1'b0;
        expect_state("R10 trigger ignored when monitor off", 8'h02, 8'h00, 1'b0);
        wr(0, 8'h42);
        expect_state("R10 enable rise pending", 8'h42, 8'h00, 1'b0);
        cyc();
        expect_state("R10 enable rise trigger", 8'h42, 8'h00, 1'b1);
        wr(0, 8'h02);
        expect_state("R12 test still open", 8'h02, 8'h00, 1'b1);
        batt_done = 1'b1; batt_fail = 1'b1; cyc(); batt_done = 1'b0; batt_fail = 1'b0;
        expect_state("R12 fail ignored when monitor off", 8'h02, 8'h00, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R1..all actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule